// File: doc/BRIEF.md
# SPI Slave Byte Engine with Select-Line Framing

This block is the receiving end of an SPI link. A remote master supplies the serial clock. The block shifts one byte in on `sdi` and one byte out on `sdo` per frame, sending the most significant bit first. The serial clock, the select line and the serial input are brought into the system clock domain with synchronisers. Edges of the serial clock are detected there, so the system clock must run at least four times faster than the serial clock. Two options set the timing on the line. `cpol` selects the idle level of the clock. `pha` selects whether data is captured on the leading edge (the idle-to-active edge) or on the trailing edge.

The byte to transmit enters through a valid/ready port into a one-entry holding register. `tx_ready` is high only when that register is empty. Received bytes leave through a valid/ready port. `rx_valid` and `rx_data` hold steady until `rx_ready` is sampled high, and the link is never stalled on the receive side. A byte that completes while the previous one is still unread is dropped, and `ovf` is raised. A one-cycle `done` pulse marks each completed byte.

Select-line control is turned on when the 4-bit `mode` field holds the value 4. In that case, a high `ss_n` aborts any byte in flight, clears the bit counter and releases `sdo` at once. With any other `mode` value, `ss_n` is ignored and the block behaves as if it were always selected. Clearing `en` also clears the bit counter and releases the output.

Top module: `spi_sel_slave`

## Requirements
- R1: When the eighth bit of a frame is captured, the byte (first captured bit in bit 7) appears on `rx_data`. `rx_valid` rises one cycle after a single-cycle `done` pulse.
- R2: The transmitted byte is the last byte accepted on the transmit port, sent MSB first. If no byte is pending when a frame completes, the next frame sends 8'h00.
- R3: If a byte completes while `rx_valid` is high and `rx_ready` is low, `ovf` is set and `rx_data` keeps the older byte. A read (`rx_valid` and `rx_ready` both high) clears `ovf`.
- R4: With `pha`=0, data is captured on the leading edge, `sdo` changes after the trailing edge, and bit 7 is already on `sdo` when the frame opens. With `pha`=1, `sdo` changes after the leading edge and data is captured on the trailing edge. The leading edge is rising when `cpol`=0 and falling when `cpol`=1.
- R5: `sdo_oe` is high only when `en` is high and either select control is off or `ss_n` is low. It drops in the same cycle `ss_n` rises, with no register in the path.
- R6: With select control on, a rise of `ss_n` in mid-byte discards the partial byte without a `done` pulse. The next frame starts again at bit 7.
- R7: While `en` is low, the bit counter is held at zero and `sdo_oe` is low. After reset, `rx_valid`, `done` and `ovf` are low and `tx_ready` is high.
- R8: A `mode` value other than 4 makes the block ignore `ss_n`. Transfers complete and `sdo_oe` stays high while `ss_n` is high.
- R9: `cfg_err` is high exactly when `en` is high, `pha` is 1 and `mode` is not 4.
- R10: A transmit byte accepted while the block is unselected or disabled is loaded into the shift register. A byte accepted during a frame is loaded when that frame completes. After each accept, `tx_ready` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; low clears the bit counter |
| mode | input | 4 | Mode field; the value 4 turns on select control |
| cpol | input | 1 | Idle level of the serial clock |
| pha | input | 1 | Capture edge: 0 = leading edge, 1 = trailing edge |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out; meaningful when `sdo_oe` is high |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | DATA_W | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Received byte consumed |
| rx_data | output | DATA_W | Received byte |
| done | output | 1 | One-cycle pulse per completed byte |
| ovf | output | 1 | Receive overwrite flag |
| cfg_err | output | 1 | Illegal option combination |

## Verification
The bench uses the default parameters: DATA_W=8 and SYNC_STAGES=2. It drives a serial half-period of eight system cycles, which is well above the four-to-one clock ratio the block needs. With 8-bit frames, every one of the four `cpol`/`pha` combinations can be run end to end. Mid-byte aborts fall at bit positions that the bench can easily count. The two-stage synchronisers give a fixed and short latency from the last capture edge to `done`, so the bench can sample `rx_data` a few cycles later without ambiguity.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  // mode field value that turns select-line control on
  localparam logic [3:0] SEL_CTL_MODE = 4'h4;
endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_sel_engine.sv
module spi_sel_engine #(
  parameter int W = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idle,
  input  logic         lead,
  input  logic         trail,
  input  logic         pha,
  input  logic         sdi_s,
  input  logic         hold_valid,
  input  logic [W-1:0] hold_data,
  output logic         take,
  output logic         out_bit,
  output logic         done,
  output logic [W-1:0] word
);
  logic [CW-1:0] cnt;
  logic [W-1:0]  tx_sh;
  logic [W-2:0]  rx_sh;
  logic          cap, shf, last;

  assign cap  = !idle && (pha ? trail : lead);
  assign shf  = !idle && (pha ? lead : trail);
  assign last = cap && (cnt == CW'(W-1));
  assign take = hold_valid && (idle || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      out_bit <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
    end else begin
      done <= last;
      if (idle) begin
        cnt <= '0;
        if (hold_valid) begin
          out_bit <= hold_data[W-1];
          tx_sh   <= pha ? hold_data : (hold_data << 1);
        end
      end else begin
        if (cap) begin
          rx_sh <= {rx_sh[W-3:0], sdi_s};
          if (last) begin
            cnt   <= '0;
            word  <= {rx_sh, sdi_s};
            tx_sh <= hold_valid ? hold_data : '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (shf) begin
          out_bit <= tx_sh[W-1];
          tx_sh   <= tx_sh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_sel_rxbuf.sv
module spi_sel_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic [W-1:0] word,
  input  logic         rx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      ovf      <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
        ovf      <= 1'b0;
      end
      if (done) begin
        if (rx_valid && !rx_ready) begin
          ovf <= 1'b1;
        end else begin
          rx_valid <= 1'b1;
          rx_data  <= word;
        end
      end
    end
  end
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3:0]        mode,
  input  logic              cpol,
  input  logic              pha,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              ovf,
  output logic              cfg_err
);
  logic [2:0] pins_s;
  logic sclk_s, ss_s, sdi_s, sclk_d;
  logic sel_ctl, idle, rise, fall, lead, trail;
  logic hold_full, take;
  logic [DATA_W-1:0] hold_data, word;

  spi_sel_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, ss_n, sdi}), .q(pins_s)
  );
  assign {sclk_s, ss_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else sclk_d <= sclk_s;
  end

  assign rise    = sclk_s && !sclk_d;
  assign fall    = !sclk_s && sclk_d;
  assign lead    = cpol ? fall : rise;
  assign trail   = cpol ? rise : fall;
  assign sel_ctl = (mode == SEL_CTL_MODE);
  assign idle    = !en || (sel_ctl && ss_s);
  assign sdo_oe  = en && (!sel_ctl || !ss_n);
  assign cfg_err = en && pha && !sel_ctl;

  // one-entry transmit holding register
  assign tx_ready = !hold_full;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (tx_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= tx_data;
    end
  end

  spi_sel_engine #(.W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .idle(idle), .lead(lead), .trail(trail),
    .pha(pha), .sdi_s(sdi_s), .hold_valid(hold_full), .hold_data(hold_data),
    .take(take), .out_bit(sdo), .done(done), .word(word)
  );

  spi_sel_rxbuf #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .ovf(ovf)
  );
endmodule

// File: rtl/spi_sel_slave_chk.sv
module spi_sel_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [3:0]        mode,
  input logic              ss_n,
  input logic              sdo_oe,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              done,
  input logic              ovf,
  input logic              cfg_err
);
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(rx_valid && !rx_ready) |=> rx_valid);
  a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    done && rx_valid && !rx_ready |=> ovf && $stable(rx_data));
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !done |=> rx_valid && $stable(rx_data));
  a_r10_tx_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 4'h4 && ss_n |-> !sdo_oe);
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sdo_oe && !cfg_err);
endmodule

bind spi_sel_slave spi_sel_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .ss_n(ss_n),
  .sdo_oe(sdo_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .done(done), .ovf(ovf), .cfg_err(cfg_err)
);

// File: tb/spi_sel_slave_tb.sv
module spi_sel_slave_tb;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, en = 0, cpol = 0, pha = 0;
  logic [3:0] mode = 4'h4;
  logic sclk = 0, ss_n = 1, sdi = 0, tx_valid = 0, rx_ready = 0;
  logic [7:0] tx_data = 0;
  logic sdo, sdo_oe, tx_ready, rx_valid, done, ovf, cfg_err;
  logic [7:0] rx_data;
  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_sel_slave u_dut (.*);

  always @(posedge clk) if (done) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1; tx_data = b;
    @(negedge clk);
    tx_valid = 0;
    cyc(3);
  endtask

  task automatic read_rx(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, rx_valid, 1);
    chk(req, rx_data, exp);
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
    cyc(1);
  endtask

  // master side: n bits of m, MSB first; returns sampled slave bits
  task automatic shift_bits(input int n, input logic [7:0] m, output logic [7:0] s);
    s = 0;
    for (int i = 7; i > 7 - n; i--) begin
      if (!pha) begin
        sdi = m[i];
        cyc(HALF);
        s[i] = sdo;
        sclk = ~cpol;
        cyc(HALF);
        sclk = cpol;
      end else begin
        cyc(HALF);
        sclk = ~cpol;
        sdi = m[i];
        cyc(HALF);
        s[i] = sdo;
        sclk = cpol;
      end
    end
    cyc(6);
  endtask

  task automatic configure(input logic p, input logic h);
    ss_n = 1; cyc(2);
    cpol = p; pha = h; sclk = p;
    cyc(6);
  endtask

  task automatic t_reset;
    chk("R7 rx_valid", rx_valid, 0);
    chk("R7 done", done, 0);
    chk("R7 ovf", ovf, 0);
    chk("R7 tx_ready", tx_ready, 1);
    chk("R7 oe", sdo_oe, 0);
  endtask

  task automatic t_mode(input logic p, input logic h);
    logic [7:0] s;
    int d0;
    configure(p, h);
    push_tx(8'hA5);
    chk("R10 ready after idle load", tx_ready, 1);
    ss_n = 0; cyc(1);
    chk("R5 oe selected", sdo_oe, 1);
    push_tx(8'h5A);
    chk("R10 ready low while pending", tx_ready, 0);
    d0 = done_cnt;
    shift_bits(8, 8'h3C, s);
    chk("R4 sdo byte1", s, 8'hA5);
    chk("R1 done once", done_cnt - d0, 1);
    read_rx("R1 rx byte1", 8'h3C);
    shift_bits(8, 8'hC3, s);
    chk("R2 sdo byte2", s, 8'h5A);
    read_rx("R4 rx byte2", 8'hC3);
    shift_bits(8, 8'h11, s);
    chk("R2 underrun zero", s, 8'h00);
    read_rx("R1 rx byte3", 8'h11);
    ss_n = 1; cyc(4);
  endtask

  task automatic t_abort;
    logic [7:0] s;
    int d0;
    configure(0, 0);
    push_tx(8'hF0);
    ss_n = 0; cyc(2);
    d0 = done_cnt;
    shift_bits(4, 8'hFF, s);
    ss_n = 1; #1;
    chk("R5 oe drops at once", sdo_oe, 0);
    cyc(6);
    chk("R6 no done on abort", done_cnt - d0, 0);
    push_tx(8'h69);
    ss_n = 0; cyc(2);
    shift_bits(8, 8'h96, s);
    chk("R6 sdo restart", s, 8'h69);
    read_rx("R6 rx restart", 8'h96);
    ss_n = 1; cyc(4);
  endtask

  task automatic t_enable;
    logic [7:0] s;
    configure(1, 0);
    ss_n = 0; cyc(2);
    shift_bits(3, 8'h00, s);
    en = 0; cyc(4);
    chk("R7 oe off when disabled", sdo_oe, 0);
    en = 1; cyc(4);
    shift_bits(8, 8'hB7, s);
    read_rx("R7 rx after re-enable", 8'hB7);
    ss_n = 1; cyc(4);
  endtask

  task automatic t_ovf;
    logic [7:0] s;
    configure(0, 1);
    ss_n = 0; cyc(2);
    shift_bits(8, 8'h12, s);
    shift_bits(8, 8'h34, s);
    chk("R3 ovf set", ovf, 1);
    read_rx("R3 old byte kept", 8'h12);
    chk("R3 ovf cleared", ovf, 0);
    chk("R3 valid cleared", rx_valid, 0);
    ss_n = 1; cyc(4);
  endtask

  task automatic t_nosel;
    logic [7:0] s;
    en = 0; mode = 4'h0; ss_n = 1;
    cpol = 0; pha = 0; sclk = 0; cyc(6);
    push_tx(8'h81);
    en = 1; cyc(2);
    chk("R8 oe ignores ss_n", sdo_oe, 1);
    chk("R9 legal combo", cfg_err, 0);
    shift_bits(8, 8'h7E, s);
    chk("R8 sdo unselected", s, 8'h81);
    read_rx("R8 rx unselected", 8'h7E);
    pha = 1; #1;
    chk("R9 illegal combo", cfg_err, 1);
    mode = 4'h4; #1;
    chk("R9 select on clears", cfg_err, 0);
    pha = 0; cyc(4);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(3);
    en = 1;
    t_mode(0, 0);
    t_mode(1, 0);
    t_mode(0, 1);
    t_mode(1, 1);
    t_abort();
    t_enable();
    t_ovf();
    t_nosel();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule